// File: doc/BRIEF.md
# SPI Port with Write-Collision Detection

This block is a single-buffered SPI shift unit. One 8-bit register is both the bus-visible data register and the serial shifter. A data write loads that register directly. A data read returns it, which after a transfer is the received byte. It runs in SPI mode 0, as master or as slave, chosen by a static mode input. As master it generates SCLK from the system clock with an even programmable divider. As slave it takes SCLK, MOSI and the active-low select through two synchronizer flops before it looks for edges.

There is no transmit buffer, so the shifter must not be overwritten while it is in use. The block keeps a protected window. The window opens when a transfer starts. It stays open past the last bit and closes only when software reads status while the complete flag is set. A data write inside the window is thrown away and raises a sticky collision flag. A data read made after the window has closed clears both flags, and the port is then ready for the next write.

Top module: `spi_wcol_port`

## Requirements
- R1: After reset the status register reads 0, `ss_no` is high, `sclk_o` is low and `miso_o` is low.
- R2: `addr_i`=0 selects the data register and `addr_i`=1 selects status. In status, bit 0 is the complete flag, bit 1 is the collision flag and bits 7:2 read 0. `rdata_o` follows `addr_i` combinationally. Writes to status change nothing and start nothing.
- R3: In master mode, a data write outside the window loads the shifter and starts a transfer. `ss_no` is low for its whole length. Bits go out MSB first. MOSI changes on SCLK falling edges and MISO is sampled on rising edges. SCLK is low whenever no master transfer is running.
- R4: The SCLK half period is max(`div_i`>>1, 1) system clocks. The complete flag appears exactly 16 half periods after the clock edge that accepts the write.
- R5: The complete flag sets once 8 bits have been shifted. The data register then holds the received byte, and a master transfer has ended by that point.
- R6: The window opens when a transfer starts: on an accepted master write, or on a synchronized falling edge of `ss_ni` in slave mode.
- R7: The window stays open after completion. A status read made while the complete flag is 1 closes it. A status read made while the flag is 0 leaves it open. A data write before that closing read is dropped and starts no transfer.
- R8: A data write inside the window leaves the shifter unchanged and sets the collision flag. The flag stays set through further dropped writes.
- R9: A data read made while the window is closed clears the complete and collision flags. A data read made while the window is open clears neither.
- R10: In slave mode, `miso_o` carries the shifter MSB. MOSI is captured on synchronized SCLK rising edges and the shifter moves on falling edges. After 8 bits the data register holds the byte that was sent.
- R11: In slave mode, a data write while `ss_ni` is high and the window is closed loads the shifter for the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| div_i | input | DIV_W | SCLK divider in master mode (even, minimum 2) |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = data, 1 = status |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| sclk_o | output | 1 | Master SCLK |
| mosi_o | output | 1 | Master serial out |
| ss_no | output | 1 | Master select, active low |
| miso_i | input | 1 | Master serial in |
| sclk_i | input | 1 | Slave SCLK in |
| mosi_i | input | 1 | Slave serial in |
| ss_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Slave serial out |

## Verification
The bench targets the window edges. It writes after the last bit but before the status read, which a design that closes the window on completion would accept, overwriting the received byte and starting a new transfer. It reads status during a transfer and then writes after completion: a design that closes the window on any status read would let that write through. It reads data while the window is still open, which an early-clearing design would use to drop the collision flag. It also checks for the complete flag one cycle before and exactly at the expected edge, at two divider settings, and issues a write right after select falls in slave mode, where a design that opens the window on the first clock edge would overwrite the preloaded byte.

// File: rtl/spi_wcol_pkg.sv
`timescale 1ns/1ps
package spi_wcol_pkg;
  localparam int WORD_W    = 8;
  localparam int BIT_CNT_W = $clog2(WORD_W);

  typedef enum logic {
    REG_DATA = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;

  localparam int STAT_DONE = 0;
  localparam int STAT_WCOL = 1;
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] half, hc_q;
  logic             sclk_q, tick;

  // half period in system clocks, floor of 1
  always_comb begin
    half = div_i >> 1;
    if (half == '0) half = DIV_W'(1);
  end

  assign tick = run_i && (hc_q == half - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q   <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      hc_q   <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      hc_q   <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      hc_q <= hc_q + DIV_W'(1);
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = tick & ~sclk_q;
  assign fall_o = tick & sclk_q;
endmodule

// File: rtl/spi_wcol_port.sv
`timescale 1ns/1ps
module spi_wcol_port
  import spi_wcol_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             ss_no,
  input  logic             miso_i,
  input  logic             sclk_i,
  input  logic             mosi_i,
  input  logic             ss_ni,
  output logic             miso_o
);
  logic [WORD_W-1:0]    shreg_q, stat;
  logic [BIT_CNT_W-1:0] bcnt_q;
  logic busy_q, sact_q, win_q, done_q, wcol_q, cap_q;
  logic ss_s, sclk_s, mosi_s, ss_d, sclk_d;
  logic m_rise, m_fall;

  // slave-side inputs: two-flop synchronizer, select idles high
  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sclk_i, mosi_i}),
    .q_o   ({ss_s, sclk_s, mosi_s})
  );

  spi_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_q),
    .div_i (div_i),
    .sclk_o(sclk_o),
    .rise_o(m_rise),
    .fall_o(m_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      ss_d   <= ss_s;
      sclk_d <= sclk_s;
    end
  end

  logic rd, wr, stat_rd, data_rd, data_wr, legal_wr, coll;
  logic start_m, start_s, rise_ev, fall_ev, last, smp_bit;

  assign rd       = req_i & ~we_i;
  assign wr       = req_i & we_i;
  assign stat_rd  = rd & (addr_i == REG_STAT);
  assign data_rd  = rd & (addr_i == REG_DATA);
  assign data_wr  = wr & (addr_i == REG_DATA);
  assign legal_wr = data_wr & ~win_q;
  assign coll     = data_wr & win_q;

  assign start_m = legal_wr & master_i;
  assign start_s = ~master_i & ~sact_q & ss_d & ~ss_s;

  assign rise_ev = busy_q ? m_rise : (sact_q & ~sclk_d & sclk_s);
  assign fall_ev = busy_q ? m_fall : (sact_q & sclk_d & ~sclk_s);
  assign smp_bit = busy_q ? miso_i : mosi_s;
  assign last    = fall_ev & (bcnt_q == BIT_CNT_W'(WORD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cap_q   <= 1'b0;
      bcnt_q  <= '0;
      busy_q  <= 1'b0;
      sact_q  <= 1'b0;
      win_q   <= 1'b0;
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
    end else begin
      // shifter: direct load or one-bit shift, never both
      if (legal_wr)     shreg_q <= wdata_i;
      else if (fall_ev) shreg_q <= {shreg_q[WORD_W-2:0], cap_q};

      if (rise_ev) cap_q <= smp_bit;

      if (start_m || start_s) bcnt_q <= '0;
      else if (fall_ev)       bcnt_q <= bcnt_q + BIT_CNT_W'(1);

      if (start_m)   busy_q <= 1'b1;
      else if (last) busy_q <= 1'b0;

      if (start_s)   sact_q <= 1'b1;
      else if (last) sact_q <= 1'b0;

      // protected window: closes only on status read with done seen
      if (start_m || start_s)      win_q <= 1'b1;
      else if (stat_rd && done_q)  win_q <= 1'b0;

      if (last)                    done_q <= 1'b1;
      else if (data_rd && !win_q)  done_q <= 1'b0;

      if (coll)                    wcol_q <= 1'b1;
      else if (data_rd && !win_q)  wcol_q <= 1'b0;
    end
  end

  always_comb begin
    stat            = '0;
    stat[STAT_DONE] = done_q;
    stat[STAT_WCOL] = wcol_q;
  end

  assign rdata_o = (addr_i == REG_STAT) ? stat : shreg_q;
  assign mosi_o  = busy_q & shreg_q[WORD_W-1];
  assign ss_no   = ~busy_q;
  assign miso_o  = sact_q & shreg_q[WORD_W-1];
endmodule

// File: rtl/spi_wcol_port_chk.sv
`timescale 1ns/1ps
module spi_wcol_port_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         master_i,
  input logic         busy_i,
  input logic         win_i,
  input logic         done_i,
  input logic         wcol_i,
  input logic         sclk_i,
  input logic         stat_rd_i,
  input logic         data_rd_i,
  input logic         data_wr_i,
  input logic         fall_ev_i,
  input logic [W-1:0] shreg_i
);
  assert_win_opens_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> win_i);

  assert_win_close_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(win_i) |-> $past(stat_rd_i && done_i));

  assert_wcol_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol_i && !(data_rd_i && !win_i)) |=> wcol_i);

  assert_drop_keeps_shreg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && win_i && !fall_ev_i) |=> $stable(shreg_i));

  assert_sclk_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sclk_i);

  assert_done_ends_xfer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_i) && master_i) |-> !busy_i);
endmodule

bind spi_wcol_port spi_wcol_port_chk #(.W(spi_wcol_pkg::WORD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .master_i (master_i),
  .busy_i   (busy_q),
  .win_i    (win_q),
  .done_i   (done_q),
  .wcol_i   (wcol_q),
  .sclk_i   (sclk_o),
  .stat_rd_i(stat_rd),
  .data_rd_i(data_rd),
  .data_wr_i(data_wr),
  .fall_ev_i(fall_ev),
  .shreg_i  (shreg_q)
);

// File: tb/spi_wcol_port_tb.sv
`timescale 1ns/1ps
module spi_wcol_port_tb;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic             master_i = 1'b1;
  logic [DIV_W-1:0] div_i = 8'd6;
  logic             req_i = 1'b0, we_i = 1'b0, addr_i = 1'b0;
  logic [7:0]       wdata_i = '0;
  logic [7:0]       rdata_o;
  logic             sclk_o, mosi_o, ss_no, miso_i, miso_o;
  logic             sclk_i = 1'b0, mosi_i = 1'b0, ss_ni = 1'b1;

  spi_wcol_port #(.DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master_i), .div_i(div_i),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .ss_no(ss_no),
    .miso_i(miso_i), .sclk_i(sclk_i), .mosi_i(mosi_i), .ss_ni(ss_ni),
    .miso_o(miso_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done_rpt = 0;

  // bench slave for master-mode runs
  int         fall_cnt = 0;
  int         fall_base = 0;
  int         sidx;
  logic [7:0] tb_tx = '0;
  logic [7:0] tb_rx = '0;
  always @(negedge sclk_o) fall_cnt <= fall_cnt + 1;
  always @(posedge sclk_o) tb_rx <= {tb_rx[6:0], mosi_o};
  always_comb begin
    sidx   = fall_cnt - fall_base;
    miso_i = (sidx >= 0 && sidx < 8) ? tb_tx[7 - sidx] : 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done_rpt) begin
      done_rpt = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(1'b1, v);
    chk("R1 status", v, 8'h00);
    chk("R1 ss_no", ss_no, 1'b1);
    chk("R1 sclk_o", sclk_o, 1'b0);
    chk("R1 miso_o", miso_o, 1'b0);
  endtask

  task automatic t_readonly();
    logic [7:0] v;
    bus_wr(1'b1, 8'hFF);
    peek(1'b1, v);
    chk("R2 status write ignored", v, 8'h00);
    chk("R2 no transfer from status write", ss_no, 1'b1);
  endtask

  // accept write, then look for done one cycle early and on the exact edge
  task automatic t_timing(input logic [7:0] div, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] v;
    int half;
    half = (div >> 1) == 0 ? 1 : (div >> 1);
    master_i = 1'b1; div_i = div;
    tb_tx = rx; fall_base = fall_cnt;
    bus_wr(1'b0, tx);
    chk("R3 ss_no low in transfer", ss_no, 1'b0);
    repeat (16 * half - 1) @(negedge clk);
    peek(1'b1, v);
    chk("R4 done not yet", v[0], 1'b0);
    @(negedge clk);
    peek(1'b1, v);
    chk("R4 done on exact edge", v[0], 1'b1);
    chk("R3 ss_no high after", ss_no, 1'b1);
    chk("R3 MSB-first tx", tb_rx, tx);
    bus_rd(1'b1, v);
    chk("R7 status at close", v, 8'h01);
    bus_rd(1'b0, v);
    chk("R5 received byte", v, rx);
    peek(1'b1, v);
    chk("R9 flags cleared", v, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    master_i = 1'b1; div_i = 8'd6;
    tb_tx = 8'h3C; fall_base = fall_cnt;
    bus_wr(1'b0, 8'hA5);
    repeat (5) @(negedge clk);
    bus_wr(1'b0, 8'hFF);
    peek(1'b1, v);
    chk("R8 wcol set, not done", v, 8'h02);
    bus_rd(1'b1, v);
    chk("R7 status read while busy", v, 8'h02);
    bus_wr(1'b0, 8'h00);
    repeat (60) @(negedge clk);
    chk("R8 shifter untouched by drops", tb_rx, 8'hA5);
    peek(1'b0, v);
    chk("R5 rx byte in data reg", v, 8'h3C);
    peek(1'b1, v);
    chk("R8 wcol sticky with done", v, 8'h03);
    bus_wr(1'b0, 8'h11);
    peek(1'b0, v);
    chk("R7 write after done still dropped", v, 8'h3C);
    chk("R7 no transfer started", ss_no, 1'b1);
    bus_rd(1'b0, v);
    chk("R9 data read in window", v, 8'h3C);
    peek(1'b1, v);
    chk("R9 no clear while window open", v, 8'h03);
    bus_rd(1'b1, v);
    chk("R7 closing status read", v, 8'h03);
    bus_rd(1'b0, v);
    chk("R9 data after close", v, 8'h3C);
    peek(1'b1, v);
    chk("R9 flags cleared after close", v, 8'h00);
    tb_tx = 8'h00; fall_base = fall_cnt;
    bus_wr(1'b0, 8'h5A);
    chk("R6 legal write reopens transfer", ss_no, 1'b0);
    peek(1'b1, v);
    chk("R6 no collision on legal write", v, 8'h00);
    repeat (60) @(negedge clk);
    bus_rd(1'b1, v);
    bus_rd(1'b0, v);
    chk("R3 second tx MSB-first", tb_rx, 8'h5A);
  endtask

  task automatic t_slave();
    logic [7:0] v;
    logic [7:0] srx;
    logic [7:0] stx;
    srx = '0; stx = 8'h5A;
    master_i = 1'b0;
    bus_wr(1'b0, 8'h96);
    peek(1'b0, v);
    chk("R11 preload with ss high", v, 8'h96);
    ss_ni = 1'b0;
    repeat (6) @(negedge clk);
    bus_wr(1'b0, 8'h00);
    peek(1'b1, v);
    chk("R6 window open at ss fall", v, 8'h02);
    peek(1'b0, v);
    chk("R8 slave shifter kept", v, 8'h96);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = stx[i];
      repeat (8) @(negedge clk);
      sclk_i = 1'b1;
      srx = {srx[6:0], miso_o};
      repeat (8) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (10) @(negedge clk);
    ss_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 slave MSB-first out", srx, 8'h96);
    peek(1'b1, v);
    chk("R5 slave done and wcol", v, 8'h03);
    bus_rd(1'b1, v);
    bus_rd(1'b0, v);
    chk("R10 slave received byte", v, 8'h5A);
    peek(1'b1, v);
    chk("R9 slave flags cleared", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_readonly();
    t_timing(8'd6, 8'hC3, 8'h81);
    t_timing(8'd1, 8'h4E, 8'hB7);
    t_collision();
    t_slave();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    report();
  end
endmodule